// File: doc/BRIEF.md
# Downstream Claim Decoder for a Bus Bridge

This block sits on the upstream side of a bus-to-bus bridge. For each transaction address and bus command presented to it, it reports in the same cycle whether the bridge should claim the cycle and pass it downstream. It also reports which address range caused the claim. Four configuration registers, written through a simple write port, set its behaviour. Two of them hold an I/O window: a base and an inclusive limit, with 4 KB granularity and a full 32-bit I/O address. One holds a memory-mapped I/O window with 1 MB granularity. One holds the enable and legacy-display control bits.

Two legacy overrides can add claims on top of the windows. The display-compatibility override claims the legacy display memory hole and the legacy display I/O ports wherever the windows are set. The colour-table snoop override claims writes to the three colour-table I/O ports. The decode path has no registers, so a new address gets an answer without waiting for a clock. Only configuration writes wait for a clock edge.

Top module: `fwd_window_decode`

## Requirements
- R1: An I/O read (cmd 0010b) or I/O write (cmd 0011b) is claimed with kind 1 when addr[31:12] lies between the I/O base block and the I/O limit block, inclusive. The I/O base block is {reg0[31:16], reg0[7:4]} and the I/O limit block is {reg1[31:16], reg1[7:4]}. Address bits [11:0] of the limit are taken as FFFh.
- R2: Bits [3:0] of write data to reg0 and reg1 have no effect on decode. These bits are read-only and fixed at 0001b.
- R3: A memory command (cmd 0110b, 0111b, 1100b, 1110b or 1111b) is claimed with kind 2 when addr[31:20] lies between reg2[15:4] (base) and reg2[31:20] (limit), inclusive.
- R4: When the memory base field is greater than the memory limit field, the memory window claims nothing.
- R5: No command other than those listed in R1 and R3 is ever claimed. I/O commands are never decoded against the memory window, and memory commands are never decoded against the I/O window.
- R6: I/O claims of any kind require reg3[0] (I/O enable). Memory claims of any kind require reg3[1] (memory enable).
- R7: With reg3[2] (display override) set, two kinds of access are claimed with kind 3, taking precedence over every other kind. The first is a memory command to 000A_0000h..000B_FFFFh. The second is an I/O command with addr[31:16]=0 and addr[9:0] in 3B0h..3BBh or 3C0h..3DFh; addr[15:10] is ignored.
- R8: With reg3[3] (colour-table snoop) set, an I/O write whose addr[9:0] is 3C6h, 3C8h or 3C9h is claimed with kind 4. An I/O read to those ports is not claimed by the snoop. With reg3[3] clear, the snoop claims nothing.
- R9: After reset every register field is 0, so nothing is claimed. A register is written only on a clock edge with cfg_we high, selected by cfg_sel (0..3). With cfg_we low, registers keep their values.
- R10: fwd_hit is 1 exactly when fwd_kind is nonzero. fwd_kind uses the encoding 0 none, 1 I/O window, 2 memory window, 3 display override, 4 colour-table snoop. A snoop claim takes precedence over a window claim.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 I/O base, 1 I/O limit, 2 memory window, 3 control) |
| cfg_wdata | input | 32 | Register write data |
| txn_addr | input | 32 | Upstream transaction address |
| txn_cmd | input | 4 | Upstream bus command |
| fwd_hit | output | 1 | Claim and forward the transaction downstream |
| fwd_kind | output | 3 | Range that produced the claim |

## Verification
The bench probes both edges of every window. These are the base address and the last byte of the limit block. A design that forgot the implied all-ones low bits, or used a strict compare, would miss one of these probes. The bench closes the memory window with base above limit, and it checks that an I/O command at a memory-window address is not claimed (and the reverse). A decoder that ignored the command class would claim those cycles. The colour-table ports are probed with reads, with a neighbouring port, with an aliased upper address, and with the snoop off. The bench also confirms that the display override wins over the snoop.

// File: rtl/fwd_dec_pkg.sv
package fwd_dec_pkg;
  localparam int ADDR_W     = 32;
  localparam int IO_GRAN_W  = 12;
  localparam int MEM_GRAN_W = 20;
  localparam int IO_BLK_W   = ADDR_W - IO_GRAN_W;
  localparam int MEM_BLK_W  = ADDR_W - MEM_GRAN_W;
  localparam int SEL_W      = 2;

  localparam logic [SEL_W-1:0] SEL_IO_BASE  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_IO_LIMIT = 2'd1;
  localparam logic [SEL_W-1:0] SEL_MEM_WIN  = 2'd2;
  localparam logic [SEL_W-1:0] SEL_CTRL     = 2'd3;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_MEM_RM = 4'b1100;
  localparam logic [3:0] CMD_MEM_RL = 4'b1110;
  localparam logic [3:0] CMD_MEM_WI = 4'b1111;

  typedef enum logic [2:0] {
    HIT_NONE = 3'd0,
    HIT_IO   = 3'd1,
    HIT_MEM  = 3'd2,
    HIT_VGA  = 3'd3,
    HIT_PAL  = 3'd4
  } hit_kind_e;

  typedef struct packed {
    logic snoop;
    logic vga;
    logic mem_en;
    logic io_en;
  } ctrl_t;
endpackage

// File: rtl/fwd_cfg_regs.sv
module fwd_cfg_regs
  import fwd_dec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic [ADDR_W-1:0]    cfg_wdata,
  output logic [IO_BLK_W-1:0]  io_base_blk,
  output logic [IO_BLK_W-1:0]  io_limit_blk,
  output logic [MEM_BLK_W-1:0] mem_base_blk,
  output logic [MEM_BLK_W-1:0] mem_limit_blk,
  output ctrl_t                ctrl
);
  logic [IO_BLK_W-1:0]  io_base_nxt, io_limit_nxt;
  logic [MEM_BLK_W-1:0] mem_base_nxt, mem_limit_nxt;
  ctrl_t                ctrl_nxt;
  logic [IO_BLK_W-1:0]  io_field;

  // upper 16 bits from the high half, addr[15:12] from bits [7:4]; [3:0] read-only
  assign io_field = {cfg_wdata[31:16], cfg_wdata[7:4]};

  always_comb begin
    io_base_nxt   = io_base_blk;
    io_limit_nxt  = io_limit_blk;
    mem_base_nxt  = mem_base_blk;
    mem_limit_nxt = mem_limit_blk;
    ctrl_nxt      = ctrl;
    if (cfg_we) begin
      unique case (cfg_sel)
        SEL_IO_BASE:  io_base_nxt  = io_field;
        SEL_IO_LIMIT: io_limit_nxt = io_field;
        SEL_MEM_WIN: begin
          mem_base_nxt  = cfg_wdata[15:4];
          mem_limit_nxt = cfg_wdata[31:20];
        end
        default:      ctrl_nxt = ctrl_t'(cfg_wdata[3:0]);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_base_blk   <= '0;
      io_limit_blk  <= '0;
      mem_base_blk  <= '0;
      mem_limit_blk <= '0;
      ctrl          <= '0;
    end else if (cfg_we) begin
      io_base_blk   <= io_base_nxt;
      io_limit_blk  <= io_limit_nxt;
      mem_base_blk  <= mem_base_nxt;
      mem_limit_blk <= mem_limit_nxt;
      ctrl          <= ctrl_nxt;
    end
  end

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(ctrl) && $stable(io_base_blk) && $stable(mem_base_blk)));
  p_ctrl_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel != SEL_CTRL) |=> $stable(ctrl));
endmodule

// File: rtl/fwd_range_match.sv
module fwd_range_match #(
  parameter int ADDR_W = 32,
  parameter int GRAN_W = 12,
  localparam int BLK_W = ADDR_W - GRAN_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BLK_W-1:0]  base_blk,
  input  logic [BLK_W-1:0]  limit_blk,
  output logic              open,
  output logic              in_range
);
  logic [BLK_W-1:0] addr_blk;

  // compare at block level: limit's low GRAN_W bits are implicitly all ones
  assign addr_blk = addr[ADDR_W-1:GRAN_W];
  assign open     = (base_blk <= limit_blk);
  assign in_range = (addr_blk >= base_blk) && (addr_blk <= limit_blk);

  always_comb begin
    if (!open) p_closed_no_match_r4: assert (!in_range);
  end
endmodule

// File: rtl/fwd_legacy_decode.sv
module fwd_legacy_decode
  import fwd_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic              vga_mem,
  output logic              vga_io,
  output logic              pal_port
);
  localparam int PORT_W = 10;
  localparam int NPAL   = 3;
  localparam logic [PORT_W-1:0] PAL_PORTS [NPAL] = '{10'h3C6, 10'h3C8, 10'h3C9};

  logic [PORT_W-1:0] port;
  logic [NPAL-1:0]   pal_hits;

  assign port    = addr[PORT_W-1:0];
  assign vga_mem = (addr[ADDR_W-1:17] == 15'h0005);
  assign vga_io  = (addr[ADDR_W-1:16] == '0) &&
                   (((port >= 10'h3B0) && (port <= 10'h3BB)) ||
                    ((port >= 10'h3C0) && (port <= 10'h3DF)));

  for (genvar p = 0; p < NPAL; p++) begin : g_pal
    assign pal_hits[p] = (port == PAL_PORTS[p]);
  end
  assign pal_port = |pal_hits;
endmodule

// File: rtl/fwd_window_decode.sv
module fwd_window_decode
  import fwd_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic [31:0] txn_addr,
  input  logic [3:0]  txn_cmd,
  output logic        fwd_hit,
  output logic [2:0]  fwd_kind
);
  logic [IO_BLK_W-1:0]  io_base_blk, io_limit_blk;
  logic [MEM_BLK_W-1:0] mem_base_blk, mem_limit_blk;
  ctrl_t                ctrl;
  logic                 io_open, io_in, mem_open, mem_in;
  logic                 vga_mem, vga_io, pal_port;
  logic                 is_io, is_io_wr, is_mem;
  hit_kind_e            kind;

  fwd_cfg_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_sel       (cfg_sel),
    .cfg_wdata     (cfg_wdata),
    .io_base_blk   (io_base_blk),
    .io_limit_blk  (io_limit_blk),
    .mem_base_blk  (mem_base_blk),
    .mem_limit_blk (mem_limit_blk),
    .ctrl          (ctrl)
  );

  fwd_range_match #(.ADDR_W(ADDR_W), .GRAN_W(IO_GRAN_W)) u_io_win (
    .addr      (txn_addr),
    .base_blk  (io_base_blk),
    .limit_blk (io_limit_blk),
    .open      (io_open),
    .in_range  (io_in)
  );

  fwd_range_match #(.ADDR_W(ADDR_W), .GRAN_W(MEM_GRAN_W)) u_mem_win (
    .addr      (txn_addr),
    .base_blk  (mem_base_blk),
    .limit_blk (mem_limit_blk),
    .open      (mem_open),
    .in_range  (mem_in)
  );

  fwd_legacy_decode u_legacy (
    .addr     (txn_addr),
    .vga_mem  (vga_mem),
    .vga_io   (vga_io),
    .pal_port (pal_port)
  );

  always_comb begin
    is_io_wr = (txn_cmd == CMD_IO_WR);
    is_io    = (txn_cmd == CMD_IO_RD) || is_io_wr;
    unique case (txn_cmd)
      CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RM, CMD_MEM_RL, CMD_MEM_WI: is_mem = 1'b1;
      default: is_mem = 1'b0;
    endcase
  end

  // priority: display override, colour-table snoop, then windows
  always_comb begin
    kind = HIT_NONE;
    if (is_io && ctrl.io_en) begin
      if (ctrl.vga && vga_io)                 kind = HIT_VGA;
      else if (ctrl.snoop && is_io_wr && pal_port) kind = HIT_PAL;
      else if (io_open && io_in)              kind = HIT_IO;
    end else if (is_mem && ctrl.mem_en) begin
      if (ctrl.vga && vga_mem)                kind = HIT_VGA;
      else if (mem_open && mem_in)            kind = HIT_MEM;
    end
  end

  assign fwd_kind = kind;
  assign fwd_hit  = (kind != HIT_NONE);

  p_io_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_io && !ctrl.io_en) |-> !fwd_hit);
  p_mem_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mem && !ctrl.mem_en) |-> !fwd_hit);
  p_mem_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_base_blk > mem_limit_blk) |-> (fwd_kind != HIT_MEM));
  p_pal_write_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_kind == HIT_PAL) |-> (txn_cmd == CMD_IO_WR && ctrl.snoop));
  p_cmd_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> (is_io || is_mem));
  p_io_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_kind == HIT_IO) |-> (is_io && txn_addr[31:12] >= io_base_blk && txn_addr[31:12] <= io_limit_blk));
endmodule

// File: tb/fwd_window_decode_bench.sv
module fwd_window_decode_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;
  localparam int NVEC = 22;

  // {cmd[3:0], addr[31:0], exp_hit, exp_kind[2:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {4'h2, 32'h0000_2000, 1'b1, 3'd1},  // R1 base edge
    {4'h3, 32'h0000_4FFF, 1'b1, 3'd1},  // R1 last byte of limit block
    {4'h2, 32'h0000_5000, 1'b0, 3'd0},  // R1 above limit
    {4'h2, 32'h0000_1FFF, 1'b0, 3'd0},  // R1 below base
    {4'h2, 32'h0001_3000, 1'b0, 3'd0},  // R1 upper half differs
    {4'h6, 32'h8000_0000, 1'b1, 3'd2},  // R3 base edge
    {4'hF, 32'h80FF_FFFF, 1'b1, 3'd2},  // R3 limit edge
    {4'h6, 32'h8100_0000, 1'b0, 3'd0},  // R3 above
    {4'h6, 32'h7FFF_FFFF, 1'b0, 3'd0},  // R3 below
    {4'hE, 32'h8000_1000, 1'b1, 3'd2},  // R3 read line
    {4'hC, 32'h8070_0000, 1'b1, 3'd2},  // R3 read multiple
    {4'h7, 32'h80F0_0004, 1'b1, 3'd2},  // R3 write
    {4'h2, 32'h8000_0000, 1'b0, 3'd0},  // R5 io cmd on mem window
    {4'h6, 32'h0000_2000, 1'b0, 3'd0},  // R5 mem cmd on io window
    {4'hA, 32'h0000_2000, 1'b0, 3'd0},  // R5 config cmd
    {4'h6, 32'h000A_0000, 1'b1, 3'd3},  // R7 mem low edge
    {4'h6, 32'h000B_FFFF, 1'b1, 3'd3},  // R7 mem high edge
    {4'h6, 32'h000C_0000, 1'b0, 3'd0},  // R7 past hole
    {4'h2, 32'h0000_03B0, 1'b1, 3'd3},  // R7 io mono range
    {4'h2, 32'h0000_73DF, 1'b1, 3'd3},  // R7 io alias, addr[15:10] ignored
    {4'h2, 32'h0000_03BC, 1'b0, 3'd0},  // R7 gap
    {4'h2, 32'h0001_03B0, 1'b0, 3'd0}   // R7 upper bits nonzero
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] txn_addr;
  logic [3:0]  txn_cmd;
  logic        fwd_hit;
  logic [2:0]  fwd_kind;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  fwd_window_decode u_fwd_window_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .txn_addr  (txn_addr),
    .txn_cmd   (txn_cmd),
    .fwd_hit   (fwd_hit),
    .fwd_kind  (fwd_kind)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input string req, input logic [3:0] cmd, input logic [31:0] addr,
                       input logic exp_hit, input logic [2:0] exp_kind);
    @(negedge clk);
    txn_cmd = cmd; txn_addr = addr;
    #1;
    n_run++;
    if (fwd_hit !== exp_hit || fwd_kind !== exp_kind) begin
      n_fail++;
      $display("FAIL %s cmd=%h addr=%h: hit=%b kind=%0d expected hit=%b kind=%0d",
               req, cmd, addr, fwd_hit, fwd_kind, exp_hit, exp_kind);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    txn_addr = '0; txn_cmd = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9 reset state: nothing claimed
    probe("R9", 4'h2, 32'h0000_0800, 1'b0, 3'd0);
    probe("R9", 4'h6, 32'h000A_0000, 1'b0, 3'd0);
    probe("R9", 4'h6, 32'h0000_0000, 1'b0, 3'd0);

    // programming; low nibble of io regs written with ones (R2)
    cfg_write(2'd0, 32'h0000_002F);
    cfg_write(2'd1, 32'h0000_004F);
    cfg_write(2'd2, 32'h80F0_8000);
    cfg_write(2'd3, 32'h0000_0007);

    for (int i = 0; i < NVEC; i++) begin
      probe($sformatf("R1/R3/R5/R7 vec%0d", i), VEC[i][39:36], VEC[i][35:4],
            VEC[i][3], VEC[i][2:0]);
    end

    // R2: low nibble had no effect on base 0x2000 / limit 0x4FFF
    probe("R2", 4'h2, 32'h0000_2000, 1'b1, 3'd1);
    probe("R2", 4'h2, 32'h0000_4FFF, 1'b1, 3'd1);

    // R9: held write data with strobe low is ignored
    @(negedge clk);
    cfg_sel = 2'd3; cfg_wdata = 32'h0;
    repeat (2) @(negedge clk);
    probe("R9", 4'h2, 32'h0000_3000, 1'b1, 3'd1);

    // R7 precedence over snoop: both on, palette write -> display kind
    cfg_write(2'd3, 32'h0000_000F);
    probe("R7", 4'h3, 32'h0000_03C6, 1'b1, 3'd3);

    // R8: snoop on, display override off
    cfg_write(2'd3, 32'h0000_000B);
    probe("R8", 4'h3, 32'h0000_03C8, 1'b1, 3'd4);
    probe("R8", 4'h3, 32'h0000_03C9, 1'b1, 3'd4);
    probe("R8", 4'h3, 32'h0000_07C6, 1'b1, 3'd4);
    probe("R8", 4'h2, 32'h0000_03C8, 1'b0, 3'd0);
    probe("R8", 4'h3, 32'h0000_03C7, 1'b0, 3'd0);
    probe("R7", 4'h2, 32'h0000_03B0, 1'b0, 3'd0);
    // R10: snoop wins over io window (window moved to cover 0x3000..0x3FFF incl 0x33C6)
    cfg_write(2'd0, 32'h0000_0030);
    cfg_write(2'd1, 32'h0000_0030);
    probe("R10", 4'h3, 32'h0000_33C6, 1'b1, 3'd4);
    probe("R10", 4'h3, 32'h0000_33C7, 1'b1, 3'd1);
    cfg_write(2'd3, 32'h0000_0003);
    probe("R8", 4'h3, 32'h0000_03C9, 1'b0, 3'd0);
    probe("R8", 4'h3, 32'h0000_33C6, 1'b1, 3'd1);

    // R6: enables gate claims
    cfg_write(2'd3, 32'h0000_0002);
    probe("R6", 4'h2, 32'h0000_3000, 1'b0, 3'd0);
    probe("R6", 4'h6, 32'h8000_0000, 1'b1, 3'd2);
    cfg_write(2'd3, 32'h0000_0005);
    probe("R6", 4'h6, 32'h8000_0000, 1'b0, 3'd0);
    probe("R6", 4'h6, 32'h000A_0000, 1'b0, 3'd0);
    probe("R6", 4'h2, 32'h0000_3000, 1'b1, 3'd1);

    // R4: memory base above limit closes the window
    cfg_write(2'd3, 32'h0000_0003);
    cfg_write(2'd2, 32'h8000_9000);
    probe("R4", 4'h6, 32'h8000_0000, 1'b0, 3'd0);
    probe("R4", 4'h6, 32'h9000_0000, 1'b0, 3'd0);
    probe("R4", 4'h6, 32'h8800_0000, 1'b0, 3'd0);
    // R3: single-block window base == limit
    cfg_write(2'd2, 32'h9000_9000);
    probe("R3", 4'h6, 32'h900F_FFFF, 1'b1, 3'd2);
    probe("R3", 4'h6, 32'h9010_0000, 1'b0, 3'd0);

    // R9: mid-run reset clears everything
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    probe("R9", 4'h6, 32'h9000_0000, 1'b0, 3'd0);
    probe("R9", 4'h2, 32'h0000_3000, 1'b0, 3'd0);

    summary();
  end
endmodule